// File: doc/BRIEF.md
# Time-to-Amplitude Converter Sequencer

This block runs one measurement of a capacitor-charging time interpolator from start to finish. While idle it keeps the charge current switched off. A start event turns the charge current on, and a stop event turns it off again, so the capacitor holds a voltage proportional to the interval. The block then waits a programmable number of clocks so that the converter input can settle. It reads one frame from a serial analogue-to-digital converter and, once the read is complete, closes a shunt switch for a programmable number of clocks to empty the capacitor. After that it waits for the next start event.

Measurements are rare, about one or two per second. The sequence is therefore built for exact, checkable ordering and not for throughput. The converted code leaves the block with a one-clock valid strobe. A sticky flag records any start event that arrives while a measurement is still in progress.

Top module: `tac_sequencer`

## Requirements
- R1: After synchronous reset (`rst` high at a rising clock edge), the outputs are `charge_en`=0, `discharge`=0, `adc_cs_n`=1, `adc_sclk`=0, `result_valid`=0 and `overrun`=0.
- R2: A `start_evt` sampled high while idle drives `charge_en` high from the next clock. `charge_en` stays high until a `stop_evt` is sampled and is low from the clock after that.
- R3: A `stop_evt` sampled while no charging is in progress is ignored. `charge_en` stays low, `adc_cs_n` stays high and no result is produced.
- R4: After `charge_en` falls, `adc_cs_n` stays high for exactly max(S,1) clocks, where S is `settle_cycles` sampled together with the stop event. It is low from the following clock.
- R5: One conversion holds `adc_cs_n` low for exactly 16 rising edges of `adc_sclk`. The block samples `adc_miso` on each rising edge, and each half period of `adc_sclk` lasts SCLK_HALF clocks. `adc_sclk` is low whenever `adc_cs_n` is high.
- R6: The 16-bit frame is received MSB first. `result_code` is the last 12 bits received, frame bits 11..0. The 4 leading bits are discarded whatever their value.
- R7: `result_valid` is high for exactly one clock per measurement, and `result_code` holds the new code in that clock.
- R8: `discharge` rises in the same clock as `result_valid` and stays high for exactly max(D,1) clocks, where D is `discharge_cycles` sampled when the conversion ends.
- R9: `discharge` is never high while `charge_en` is high or while `adc_cs_n` is low.
- R10: A `start_evt` sampled while a measurement is in progress, from charging through the last discharge clock, does not alter the sequence. It sets `overrun`, which stays set until reset.
- R11: Once `discharge` has fallen, the next `start_evt` begins a new measurement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_evt | input | 1 | Start event, one clock wide |
| stop_evt | input | 1 | Stop event, one clock wide |
| settle_cycles | input | CNT_W | Settling delay in clocks |
| discharge_cycles | input | CNT_W | Shunt-switch on time in clocks |
| adc_miso | input | 1 | Serial data from the converter |
| charge_en | output | 1 | Charge current on |
| discharge | output | 1 | Shunt switch closed |
| adc_cs_n | output | 1 | Converter chip select, active low |
| adc_sclk | output | 1 | Converter serial clock |
| result_code | output | CODE_BITS | Converted code |
| result_valid | output | 1 | One-clock strobe for result_code |
| overrun | output | 1 | Sticky flag: start event arrived while busy |

## Verification
The critical collision is a start event that lands in the last discharge clock, the same clock in which the sequencer drops back to idle. The bench drives the start exactly then, counting discharge clocks from the valid strobe. It then checks that `overrun` is set and that `charge_en` stays low afterwards. The second collision is a start and a stop sampled in one idle clock. The bench checks that charging begins and that the stop is ignored, since `charge_en` is still high two clocks later.

// File: rtl/tac_pkg.sv
package tac_pkg;

    localparam int FRAME_BITS = 16;
    localparam int CODE_BITS  = 12;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHARGING,
        ST_SETTLE,
        ST_CONVERT,
        ST_DISCHARGE
    } tac_state_e;

    typedef struct packed {
        logic [CODE_BITS-1:0] code;
        logic                 valid;
    } tac_result_t;

    function automatic logic busy_state(input tac_state_e s);
        return s != ST_IDLE;
    endfunction

endpackage

// File: rtl/tac_timer.sv
module tac_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - CNT_W'(1);
    end

    // a count of zero or one ends the interval in the current clock
    assign expired = (cnt_q <= CNT_W'(1));

    AST_TIMER_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
        (!load && cnt_q == '0) |=> (cnt_q == '0)); // R8

endmodule

// File: rtl/tac_adc_reader.sv
module tac_adc_reader #(
    parameter int FRAME_BITS = 16,
    parameter int CODE_BITS  = 12,
    parameter int SCLK_HALF  = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic                 miso,
    output logic                 cs_n,
    output logic                 sclk,
    output logic                 done,
    output logic [CODE_BITS-1:0] data
);
    localparam int DIV_W = $clog2(SCLK_HALF) + 1;
    localparam int BIT_W = $clog2(FRAME_BITS);

    logic                  busy_q;
    logic                  sclk_q;
    logic [DIV_W-1:0]      div_q;
    logic [BIT_W-1:0]      falls_q;
    logic [FRAME_BITS-1:0] shreg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q  <= 1'b0;
            sclk_q  <= 1'b0;
            div_q   <= '0;
            falls_q <= '0;
            shreg_q <= '0;
            done    <= 1'b0;
            data    <= '0;
        end else begin
            done <= 1'b0;
            if (!busy_q) begin
                busy_q  <= start;
                div_q   <= '0;
                falls_q <= '0;
                sclk_q  <= 1'b0;
            end else if (div_q == DIV_W'(SCLK_HALF - 1)) begin
                div_q  <= '0;
                sclk_q <= ~sclk_q;
                if (!sclk_q) begin
                    shreg_q <= {shreg_q[FRAME_BITS-2:0], miso};
                end else if (falls_q == BIT_W'(FRAME_BITS - 1)) begin
                    busy_q <= 1'b0;
                    done   <= 1'b1;
                    data   <= shreg_q[CODE_BITS-1:0];
                end else begin
                    falls_q <= falls_q + BIT_W'(1);
                end
            end else begin
                div_q <= div_q + DIV_W'(1);
            end
        end
    end

    assign cs_n = ~busy_q;
    assign sclk = sclk_q;

    AST_SCLK_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
        sclk |-> !cs_n); // R5
    AST_DONE_ENDS_FRAME: assert property (@(posedge clk) disable iff (rst)
        done |-> (cs_n && !sclk)); // R5

endmodule

// File: rtl/tac_sequencer.sv
module tac_sequencer
    import tac_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int SCLK_HALF = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start_evt,
    input  logic                 stop_evt,
    input  logic [CNT_W-1:0]     settle_cycles,
    input  logic [CNT_W-1:0]     discharge_cycles,
    input  logic                 adc_miso,
    output logic                 charge_en,
    output logic                 discharge,
    output logic                 adc_cs_n,
    output logic                 adc_sclk,
    output logic [CODE_BITS-1:0] result_code,
    output logic                 result_valid,
    output logic                 overrun
);
    tac_state_e           state_q, state_d;
    logic                 t_load, t_expired;
    logic [CNT_W-1:0]     t_val;
    logic                 conv_start, rd_done;
    logic [CODE_BITS-1:0] rd_data;
    tac_result_t          res_q;
    logic                 ovr_q;

    always_comb begin
        state_d    = state_q;
        t_load     = 1'b0;
        t_val      = settle_cycles;
        conv_start = 1'b0;
        unique case (state_q)
            ST_IDLE:     if (start_evt) state_d = ST_CHARGING;
            ST_CHARGING: if (stop_evt) begin
                state_d = ST_SETTLE;
                t_load  = 1'b1;
                t_val   = settle_cycles;
            end
            ST_SETTLE:   if (t_expired) begin
                state_d    = ST_CONVERT;
                conv_start = 1'b1;
            end
            ST_CONVERT:  if (rd_done) begin
                state_d = ST_DISCHARGE;
                t_load  = 1'b1;
                t_val   = discharge_cycles;
            end
            ST_DISCHARGE: if (t_expired) state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            res_q   <= '0;
            ovr_q   <= 1'b0;
        end else begin
            state_q     <= state_d;
            res_q.valid <= 1'b0;
            if (state_q == ST_CONVERT && rd_done) begin
                res_q.code  <= rd_data;
                res_q.valid <= 1'b1;
            end
            if (start_evt && busy_state(state_q))
                ovr_q <= 1'b1;
        end
    end

    tac_timer #(.CNT_W(CNT_W)) i_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (t_load),
        .load_val (t_val),
        .expired  (t_expired)
    );

    tac_adc_reader #(
        .FRAME_BITS (FRAME_BITS),
        .CODE_BITS  (CODE_BITS),
        .SCLK_HALF  (SCLK_HALF)
    ) i_reader (
        .clk   (clk),
        .rst   (rst),
        .start (conv_start),
        .miso  (adc_miso),
        .cs_n  (adc_cs_n),
        .sclk  (adc_sclk),
        .done  (rd_done),
        .data  (rd_data)
    );

    assign charge_en    = (state_q == ST_CHARGING);
    assign discharge    = (state_q == ST_DISCHARGE);
    assign result_code  = res_q.code;
    assign result_valid = res_q.valid;
    assign overrun      = ovr_q;

    AST_CHARGE_ON_START: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && start_evt) |=> charge_en); // R2
    AST_STOP_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && stop_evt && !start_evt) |=> !charge_en); // R3
    AST_VALID_ONE_CLOCK: assert property (@(posedge clk) disable iff (rst)
        result_valid |=> !result_valid); // R7
    AST_VALID_WITH_DISCHARGE: assert property (@(posedge clk) disable iff (rst)
        result_valid |-> (discharge && !$past(discharge))); // R8
    AST_DISCHARGE_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        discharge |-> (!charge_en && adc_cs_n)); // R9
    AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (rst)
        overrun |=> overrun); // R10

endmodule

// File: tb/test_tac_sequencer.sv
module test_tac_sequencer;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 16;
    localparam int NVEC       = 5;
    // fields: settle, discharge, charge clocks, frame
    localparam logic [63:0] VECS [NVEC] = '{
        {16'd1,  16'd1, 16'd3,  16'h0ABC},
        {16'd0,  16'd0, 16'd1,  16'h0FFF},
        {16'd5,  16'd4, 16'd10, 16'h0001},
        {16'd12, 16'd2, 16'd7,  16'hF800},
        {16'd3,  16'd7, 16'd2,  16'h5555}
    };

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start_evt = 1'b0;
    logic             stop_evt = 1'b0;
    logic [CNT_W-1:0] settle_cycles = '0;
    logic [CNT_W-1:0] discharge_cycles = '0;
    logic             adc_miso;
    logic             charge_en, discharge, adc_cs_n, adc_sclk;
    logic [11:0]      result_code;
    logic             result_valid, overrun;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tac_sequencer #(.CNT_W(CNT_W), .SCLK_HALF(2)) i_tac_sequencer (
        .clk(clk), .rst(rst), .start_evt(start_evt), .stop_evt(stop_evt),
        .settle_cycles(settle_cycles), .discharge_cycles(discharge_cycles),
        .adc_miso(adc_miso), .charge_en(charge_en), .discharge(discharge),
        .adc_cs_n(adc_cs_n), .adc_sclk(adc_sclk), .result_code(result_code),
        .result_valid(result_valid), .overrun(overrun)
    );

    // converter stub: new bit after each falling serial clock edge
    logic [15:0] frame = '0;
    int          idx = 0;
    always @(negedge adc_cs_n) idx = 0;
    always @(negedge adc_sclk) if (!adc_cs_n) idx = idx + 1;
    assign adc_miso = (!adc_cs_n && idx < 16) ? frame[15 - idx] : 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic run_meas(input int s, input int d, input int chlen,
                            input logic [15:0] f, input bit ovr_charge,
                            input bit ovr_end);
        int exp_s, exp_d, n, rises, k;
        logic prev;
        exp_s = (s < 1) ? 1 : s;
        exp_d = (d < 1) ? 1 : d;
        settle_cycles = CNT_W'(s);
        discharge_cycles = CNT_W'(d);
        frame = f;
        start_evt = 1'b1;
        @(negedge clk);
        start_evt = 1'b0;
        chk(charge_en === 1'b1, "R2 charge on", int'(charge_en), 1);
        for (int i = 1; i < chlen; i++) begin
            if (ovr_charge && i == 1) start_evt = 1'b1;
            @(negedge clk);
            start_evt = 1'b0;
        end
        chk(charge_en === 1'b1, "R2 charge held", int'(charge_en), 1);
        stop_evt = 1'b1;
        @(negedge clk);
        stop_evt = 1'b0;
        chk(charge_en === 1'b0, "R2 charge off", int'(charge_en), 0);
        n = 0;
        while (adc_cs_n === 1'b1) begin n++; @(negedge clk); end
        chk(n == exp_s, "R4 settle clocks", n, exp_s);
        rises = 0;
        prev = adc_sclk;
        while (adc_cs_n === 1'b0) begin
            if (adc_sclk && !prev) rises++;
            prev = adc_sclk;
            chk(discharge === 1'b0, "R9 no discharge in read", int'(discharge), 0);
            @(negedge clk);
        end
        chk(rises == 16, "R5 sclk rises", rises, 16);
        chk(adc_sclk === 1'b0, "R5 sclk idle", int'(adc_sclk), 0);
        while (result_valid !== 1'b1) @(negedge clk);
        chk(result_code == f[11:0], "R6 code", int'(result_code), int'(f[11:0]));
        chk(discharge === 1'b1, "R8 discharge with valid", int'(discharge), 1);
        k = 0;
        while (discharge === 1'b1) begin
            k++;
            if (k >= 2) chk(result_valid === 1'b0, "R7 single strobe", int'(result_valid), 0);
            chk(charge_en === 1'b0, "R9 no charge in discharge", int'(charge_en), 0);
            if (ovr_end && k == exp_d) start_evt = 1'b1;
            @(negedge clk);
            start_evt = 1'b0;
        end
        chk(k == exp_d, "R8 discharge clocks", k, exp_d);
        chk(result_valid === 1'b0, "R7 strobe ended", int'(result_valid), 0);
        chk(charge_en === 1'b0, "R10 idle after", int'(charge_en), 0);
    endtask

    initial begin
        do_reset();
        // R1 reset state
        chk(charge_en === 1'b0 && discharge === 1'b0, "R1 switches", int'({charge_en, discharge}), 0);
        chk(adc_cs_n === 1'b1 && adc_sclk === 1'b0, "R1 adc idle", int'({adc_cs_n, adc_sclk}), 2);
        chk(result_valid === 1'b0 && overrun === 1'b0, "R1 flags", int'({result_valid, overrun}), 0);

        // R3 stop with no start
        stop_evt = 1'b1;
        @(negedge clk);
        stop_evt = 1'b0;
        repeat (4) begin
            chk(charge_en === 1'b0 && adc_cs_n === 1'b1 && result_valid === 1'b0,
                "R3 stray stop", int'({charge_en, adc_cs_n, result_valid}), 2);
            @(negedge clk);
        end

        // table of measurements, R2 R4 R5 R6 R7 R8 R9 R11
        for (int v = 0; v < NVEC; v++) begin
            run_meas(int'(VECS[v][63:48]), int'(VECS[v][47:32]), int'(VECS[v][31:16]),
                     VECS[v][15:0], 1'b0, 1'b0);
            chk(overrun === 1'b0, "R11 no overrun", int'(overrun), 0);
            repeat (2) @(negedge clk);
        end

        // start and stop in the same idle clock: stop ignored
        settle_cycles = CNT_W'(2);
        discharge_cycles = CNT_W'(2);
        frame = 16'h0123;
        start_evt = 1'b1;
        stop_evt = 1'b1;
        @(negedge clk);
        start_evt = 1'b0;
        stop_evt = 1'b0;
        @(negedge clk);
        chk(charge_en === 1'b1, "R3 stop ignored with start", int'(charge_en), 1);
        stop_evt = 1'b1;
        @(negedge clk);
        stop_evt = 1'b0;
        while (result_valid !== 1'b1) @(negedge clk);
        chk(result_code == 12'h123, "R6 code after collision", int'(result_code), 'h123);
        while (discharge === 1'b1) @(negedge clk);

        // R10 start during charging leaves the measurement intact
        run_meas(2, 2, 4, 16'h07E5, 1'b1, 1'b0);
        chk(overrun === 1'b1, "R10 overrun set in charge", int'(overrun), 1);
        do_reset();
        chk(overrun === 1'b0, "R1 overrun cleared", int'(overrun), 0);

        // R10 start in the last discharge clock: dropped, flag set
        run_meas(1, 3, 2, 16'h0C3A, 1'b0, 1'b1);
        chk(overrun === 1'b1, "R10 overrun at end", int'(overrun), 1);
        repeat (3) begin
            chk(charge_en === 1'b0, "R10 late start dropped", int'(charge_en), 0);
            @(negedge clk);
        end
        // R11 new start accepted afterwards
        run_meas(4, 1, 3, 16'h0456, 1'b0, 1'b0);
        chk(overrun === 1'b1, "R10 overrun sticky", int'(overrun), 1);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule